// File: doc/BRIEF.md
# Locality Ownership Arbiter

This block decides which of several numbered requesters, called localities, owns a shared command interface at any moment. Software reaches it through one access-register port per locality. A write carries command bits. A read returns a status byte for the selected locality. The block holds either exactly one owner or none, and the value after reset is none. It supports three operations: a cooperative request, a voluntary release, and a forced takeover. In a forced takeover a higher-numbered locality claims the interface from a lower one.

A forced takeover does not move ownership at once. The block first asserts `abort_req` and keeps it high until the surrounding logic answers with `abort_done`, and only then installs the new owner. Every change of owner produces a one-cycle `loc_changed` pulse for the interrupt logic. The current owner is always visible on `active_loc`.

The controller has three states. In FREE there is no owner. In HELD one locality owns the interface. In ABORT a takeover is waiting for the abort handshake. The transitions are:
- FREE→HELD when a request is granted.
- FREE→ABORT or HELD→ABORT when a takeover is accepted.
- HELD→HELD when a release hands ownership to a waiting requester.
- HELD→FREE when a release finds no requester.
- ABORT→HELD when `abort_done` arrives.

Top module: `loc_arb`

## Requirements
- R1: After reset, `active_loc` is 7 (none), `abort_req` and `loc_changed` are low, and every locality reads 0x80, which means only bit 7 (register valid) is set.
- R2: A request command (`wr_cmd` bit 0) in state FREE makes the writer the owner on the next cycle. The owner's status byte then shows bit 5 (active).
- R3: A request from a non-owner while another locality owns the interface sets the writer's status bit 1 (request). Bit 2 (pending) reads 1 for a locality exactly when some other locality has bit 1 set.
- R4: A release command (`wr_cmd` bit 3) written by the owner passes ownership to the highest-numbered locality with a request outstanding, and clears that locality's request. If no locality is requesting, the owner becomes 7 (none) and the state returns to FREE.
- R5: A release written by a non-owner only clears the writer's own request bit. The owner does not change and no event is produced.
- R6: A takeover command (`wr_cmd` bit 1) is accepted only when all of the following hold:
  - no owner exists, or the writer's number is higher than the owner's;
  - the writer has no takeover pending;
  - no higher-numbered locality has a takeover pending.
  An accepted takeover raises `abort_req` on the next cycle. Status bit 3 always reads 0.
- R7: An accepted takeover cancels any pending takeover from lower localities, and at most one takeover is pending at any time. The owner stays unchanged while `abort_req` is high. On `abort_done` the locality that made the latest accepted takeover becomes the owner.
- R8: When ownership moves by takeover, the old owner loses only its active bit and gains status bit 4 (been seized). The new owner has its request cleared, and `loc_changed` pulses.
- R9: A clear-seized command (`wr_cmd` bit 2) clears the writer's bit 4.
- R10: Command bits in one write are decoded by priority: release first, then takeover, then request. While `abort_req` is high, request and release commands have no effect. `abort_done` outside state ABORT is ignored.
- R11: Writes with `wr_loc` of 5 or more are ignored. Reads with `rd_loc` of 5 or more return 0xFF.
- R12: Every change of owner, including a change to none, produces a `loc_changed` pulse of exactly one cycle, aligned with the new value of `active_loc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Access-register write strobe |
| wr_loc | input | 3 | Locality being written |
| wr_cmd | input | 4 | Command bits: 0 request, 1 takeover, 2 clear seized, 3 release |
| rd_loc | input | 3 | Locality being read |
| rd_data | output | 8 | Status byte of `rd_loc` (combinational) |
| abort_done | input | 1 | Abort handshake completion |
| abort_req | output | 1 | Abort of the current command requested |
| active_loc | output | 3 | Current owner, 7 when none |
| loc_changed | output | 1 | One-cycle pulse on a change of owner |

## Verification
The embedded properties assume that `abort_done` comes only from the outside handshake. They make no assumption about when it arrives relative to writes. They also assume that write commands are sampled on a clock edge with `wr_loc` stable. The stimulus changes inputs only on the falling edge and fires `abort_done` at random, including outside state ABORT and in the same cycle as a competing takeover. The stimulus also mixes in out-of-range localities and multi-bit commands. These cases show that the ignore and priority rules hold under arbitrary orderings.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;

    typedef enum logic [1:0] {
        ARB_FREE  = 2'd0,
        ARB_HELD  = 2'd1,
        ARB_ABORT = 2'd2
    } arb_state_e;

    // write command bit positions
    localparam int CMD_REQ     = 0;
    localparam int CMD_SEIZE   = 1;
    localparam int CMD_CLR_SZD = 2;
    localparam int CMD_REL     = 3;
    localparam int CMD_W       = 4;

    // status byte bit positions
    localparam int ST_REQ    = 1;
    localparam int ST_PEND   = 2;
    localparam int ST_SEIZED = 4;
    localparam int ST_ACTIVE = 5;
    localparam int ST_VALID  = 7;

endpackage

// File: rtl/loc_arb_prio.sv
module loc_arb_prio #(
    parameter int N = 5,
    parameter int W = 3
) (
    input  logic [N-1:0] vec,
    output logic         hit,
    output logic [W-1:0] idx
);
    // highest set index wins
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                hit = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/loc_arb_view.sv
module loc_arb_view
    import loc_arb_pkg::*;
#(
    parameter int N = 5,
    parameter int W = 3
) (
    input  logic [W-1:0] rd_loc,
    input  logic [W-1:0] own,
    input  logic [N-1:0] req,
    input  logic [N-1:0] seized,
    output logic [7:0]   rd_data
);
    localparam logic [W-1:0] LOC_LIM = W'(N);

    logic [N-1:0] others;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            others[i] = req[i] && (W'(i) != rd_loc);
        end
    end

    always_comb begin
        rd_data = 8'hFF;
        if (rd_loc < LOC_LIM) begin
            rd_data            = 8'h00;
            rd_data[ST_VALID]  = 1'b1;
            rd_data[ST_ACTIVE] = (own == rd_loc);
            rd_data[ST_SEIZED] = seized[rd_loc];
            rd_data[ST_PEND]   = |others;
            rd_data[ST_REQ]    = req[rd_loc];
        end
    end
endmodule

// File: rtl/loc_arb.sv
module loc_arb
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int IDX_W   = $clog2(NUM_LOC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_loc,
    input  logic [CMD_W-1:0]  wr_cmd,
    input  logic [IDX_W-1:0]  rd_loc,
    output logic [7:0]        rd_data,
    input  logic              abort_done,
    output logic              abort_req,
    output logic [IDX_W-1:0]  active_loc,
    output logic              loc_changed
);
    localparam logic [IDX_W-1:0] LOC_NONE = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] LOC_LIM  = IDX_W'(NUM_LOC);

    arb_state_e           state_q, n_state;
    logic [IDX_W-1:0]     own_q, n_own, next_q, n_next;
    logic [NUM_LOC-1:0]   req_q, n_req, seize_q, n_seize, seized_q, n_seized;
    logic                 chg_q, n_chg;

    logic                 wr_ok, is_owner, has_owner;
    logic                 do_rel, do_seize, do_req, higher_seize, seize_ok;
    logic [NUM_LOC-1:0]   take_seize, above;
    logic                 req_hit;
    logic [IDX_W-1:0]     req_top;

    // command decode, priority release > takeover > request
    assign wr_ok     = wr_en && (wr_loc < LOC_LIM);
    assign is_owner  = (own_q == wr_loc);
    assign has_owner = (own_q != LOC_NONE);
    assign do_rel    = wr_ok && wr_cmd[CMD_REL];
    assign do_seize  = wr_ok && !wr_cmd[CMD_REL] && wr_cmd[CMD_SEIZE];
    assign do_req    = wr_ok && !wr_cmd[CMD_REL] && !wr_cmd[CMD_SEIZE] && wr_cmd[CMD_REQ];

    always_comb begin
        for (int i = 0; i < NUM_LOC; i++) begin
            above[i]      = (IDX_W'(i) > wr_loc);
            take_seize[i] = (IDX_W'(i) == wr_loc) ? 1'b1 :
                            (IDX_W'(i) <  wr_loc) ? 1'b0 : seize_q[i];
        end
    end

    assign higher_seize = |(seize_q & above);
    assign seize_ok     = do_seize && (!has_owner || (wr_loc > own_q))
                          && !seize_q[wr_loc] && !higher_seize;

    loc_arb_prio #(.N(NUM_LOC), .W(IDX_W)) u_prio (
        .vec (req_q),
        .hit (req_hit),
        .idx (req_top)
    );

    loc_arb_view #(.N(NUM_LOC), .W(IDX_W)) u_view (
        .rd_loc  (rd_loc),
        .own     (own_q),
        .req     (req_q),
        .seized  (seized_q),
        .rd_data (rd_data)
    );

    // next-state and datapath update
    always_comb begin
        n_state  = state_q;
        n_own    = own_q;
        n_next   = next_q;
        n_req    = req_q;
        n_seize  = seize_q;
        n_seized = seized_q;
        n_chg    = 1'b0;
        if (wr_ok && wr_cmd[CMD_CLR_SZD]) n_seized[wr_loc] = 1'b0;
        unique case (state_q)
            ARB_FREE: begin
                if (do_rel) begin
                    n_req[wr_loc] = 1'b0;
                end else if (seize_ok) begin
                    n_seize = take_seize;
                    n_next  = wr_loc;
                    n_state = ARB_ABORT;
                end else if (do_req) begin
                    n_own         = wr_loc;
                    n_req[wr_loc] = 1'b0;
                    n_chg         = 1'b1;
                    n_state       = ARB_HELD;
                end
            end
            ARB_HELD: begin
                if (do_rel) begin
                    if (is_owner) begin
                        n_chg = 1'b1;
                        if (req_hit) begin
                            n_own          = req_top;
                            n_req[req_top] = 1'b0;
                        end else begin
                            n_own   = LOC_NONE;
                            n_state = ARB_FREE;
                        end
                    end else begin
                        n_req[wr_loc] = 1'b0;
                    end
                end else if (seize_ok) begin
                    n_seize = take_seize;
                    n_next  = wr_loc;
                    n_state = ARB_ABORT;
                end else if (do_req && !is_owner) begin
                    n_req[wr_loc] = 1'b1;
                end
            end
            ARB_ABORT: begin
                if (seize_ok) begin
                    n_seize = take_seize;
                    n_next  = wr_loc;
                end
                if (abort_done) begin
                    if (has_owner) n_seized[own_q] = 1'b1;
                    n_req[n_next] = 1'b0;
                    n_seize       = '0;
                    n_own         = n_next;
                    n_chg         = 1'b1;
                    n_state       = ARB_HELD;
                end
            end
            default: n_state = ARB_FREE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_FREE;
        else        state_q <= n_state;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q    <= LOC_NONE;
            next_q   <= LOC_NONE;
            req_q    <= '0;
            seize_q  <= '0;
            seized_q <= '0;
            chg_q    <= 1'b0;
        end else begin
            own_q    <= n_own;
            next_q   <= n_next;
            req_q    <= n_req;
            seize_q  <= n_seize;
            seized_q <= n_seized;
            chg_q    <= n_chg;
        end
    end

    // outputs
    always_comb begin
        active_loc  = own_q;
        abort_req   = (state_q == ARB_ABORT);
        loc_changed = chg_q;
    end

    p_event_moves_owner_r12: assert property (@(posedge clk) disable iff (!rst_n)
        loc_changed |-> (active_loc != $past(active_loc)));

    p_owner_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |-> $stable(active_loc));

    p_abort_exit_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(abort_req) |-> loc_changed);

    p_single_seize_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(seize_q));

    p_seize_tracks_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|seize_q) == abort_req);

    p_owner_not_requesting_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_loc != LOC_NONE) |-> !req_q[active_loc]);

endmodule

// File: tb/tb_loc_arb.sv
`timescale 1ns/100ps
module tb_loc_arb;
    localparam int N = 5;

    logic       clk = 1'b0;
    logic       rst_n, wr_en, abort_done;
    logic [2:0] wr_loc, rd_loc, active_loc;
    logic [3:0] wr_cmd;
    logic [7:0] rd_data;
    logic       abort_req, loc_changed;

    always #5 clk = ~clk;

    loc_arb dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_loc(wr_loc), .wr_cmd(wr_cmd),
        .rd_loc(rd_loc), .rd_data(rd_data), .abort_done(abort_done),
        .abort_req(abort_req), .active_loc(active_loc), .loc_changed(loc_changed)
    );

    int total = 0, bad = 0;

    // behavioural model
    int       m_own, m_next;
    bit [4:0] m_req, m_seize, m_seized;
    bit       m_abort, m_chg;

    task automatic chk(string tag, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int exp_read(int i);
        int v;
        if (i >= N) return 255;
        v = 128;
        if (m_own == i)  v |= 32;
        if (m_seized[i]) v |= 16;
        if ((m_req & ~(5'b1 << i)) != 0) v |= 4;
        if (m_req[i])    v |= 2;
        return v;
    endfunction

    task automatic check_all(string tag);
        chk(tag, "active_loc", int'(active_loc), m_own);
        chk(tag, "abort_req", int'(abort_req), int'(m_abort));
        chk(tag, "loc_changed", int'(loc_changed), int'(m_chg));
        for (int i = 0; i < 7; i++) begin
            rd_loc = i[2:0];
            #0.5;
            chk(tag, $sformatf("status[%0d]", i), int'(rd_data), exp_read(i));
        end
    endtask

    task automatic model_step(bit we, int loc, bit [3:0] c, bit done);
        bit wok, rel, sz, rq, hs, sok;
        int newo;
        m_chg = 0;
        wok = we && (loc < N);
        rel = wok && c[3];
        sz  = wok && !c[3] && c[1];
        rq  = wok && !c[3] && !c[1] && c[0];
        hs  = 0;
        if (wok) for (int j = loc + 1; j < N; j++) if (m_seize[j]) hs = 1;
        sok = sz && (m_own == 7 || loc > m_own) && !m_seize[loc] && !hs;
        if (wok && c[2]) m_seized[loc] = 0;
        if (m_abort) begin
            if (sok) begin
                for (int j = 0; j < loc; j++) m_seize[j] = 0;
                m_seize[loc] = 1;
                m_next = loc;
            end
            if (done) begin
                if (m_own != 7) m_seized[m_own] = 1;
                m_req[m_next] = 0;
                m_seize = 0;
                m_own = m_next;
                m_abort = 0;
                m_chg = 1;
            end
        end else if (rel) begin
            if (m_own == loc) begin
                newo = 7;
                for (int j = 0; j < N; j++) if (m_req[j]) newo = j;
                if (newo != 7) m_req[newo] = 0;
                m_own = newo;
                m_chg = 1;
            end else m_req[loc] = 0;
        end else if (sok) begin
            for (int j = 0; j < loc; j++) m_seize[j] = 0;
            m_seize[loc] = 1;
            m_next = loc;
            m_abort = 1;
        end else if (rq) begin
            if (m_own == 7) begin
                m_own = loc;
                m_req[loc] = 0;
                m_chg = 1;
            end else if (m_own != loc) m_req[loc] = 1;
        end
    endtask

    task automatic step(string tag, bit we, int loc, bit [3:0] c, bit done);
        wr_en = we; wr_loc = loc[2:0]; wr_cmd = c; abort_done = done;
        @(posedge clk);
        model_step(we, loc, c, done);
        @(negedge clk);
        wr_en = 0; abort_done = 0;
        check_all(tag);
    endtask

    localparam bit [3:0] C_REQ = 4'b0001, C_SZ = 4'b0010, C_CLR = 4'b0100, C_REL = 4'b1000;

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; wr_en = 0; wr_loc = 0; wr_cmd = 0; rd_loc = 0; abort_done = 0;
        m_own = 7; m_next = 7; m_req = 0; m_seize = 0; m_seized = 0; m_abort = 0; m_chg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        check_all("R1");

        step("R2", 1, 1, C_REQ, 0);          // loc1 owns from FREE
        step("R3", 1, 3, C_REQ, 0);          // pending requests
        step("R3", 1, 2, C_REQ, 0);
        step("R5", 1, 0, C_REL, 0);          // non-owner release, nothing pending
        step("R5", 1, 2, C_REL, 0);          // non-owner clears own request
        step("R3", 1, 2, C_REQ, 0);
        step("R4", 1, 1, C_REL, 0);          // hand to highest requester 3
        step("R4", 1, 3, C_REL, 0);          // to 2
        step("R12", 1, 2, C_REL, 0);         // to none
        step("R2", 1, 0, C_REQ, 0);
        step("R6", 1, 2, C_SZ, 0);           // accepted
        step("R6", 1, 1, C_SZ, 0);           // blocked by higher pending
        step("R7", 1, 4, C_SZ, 0);           // cancels 2
        step("R6", 1, 4, C_SZ, 0);           // already pending
        step("R10", 1, 1, C_REQ, 0);         // ignored during abort
        step("R10", 1, 0, C_REL, 0);         // ignored during abort
        step("R8", 0, 0, 4'b0000, 1);        // transfer to 4
        step("R9", 1, 0, C_CLR, 0);
        step("R6", 1, 2, C_SZ, 0);           // lower than owner: ignored
        step("R10", 1, 1, C_REQ, 0);
        step("R10", 1, 1, 4'b1011, 0);       // release wins, clears request only
        step("R11", 1, 6, C_REQ, 0);
        step("R11", 1, 5, C_SZ, 0);
        step("R10", 0, 0, 4'b0000, 1);       // done outside abort

        for (int n = 0; n < 3000; n++) begin
            int r, loc;
            bit [3:0] c;
            r = $urandom_range(0, 9);
            loc = $urandom_range(0, 6);
            case (r)
                0, 1:    c = C_REL;
                2, 3, 4: c = C_SZ;
                5, 6, 7: c = C_REQ;
                8:       c = C_CLR;
                default: c = 4'($urandom);
            endcase
            step("R7", $urandom_range(0, 3) != 0, loc, c, $urandom_range(0, 4) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule